// File: doc/BRIEF.md
# Wiper Position Register with Retained Store

This block keeps the 7-bit code that selects a tap on a resistor ladder. It has two registers. The first is a volatile position register that drives the tap code directly. The second is a retained register that models nonvolatile storage and keeps its value across the block's reset. A bus decoder upstream turns serial transactions into single-cycle requests. Each request is a write, a read or a one-position step, and a write or read is aimed at one of the two registers.

A reset models a loss of supply. On reset the position register parks at mid-scale. Once reset is released and a programmable settle time has passed, the position register takes the retained value. A write to the retained register also loads the position register, then holds the block busy for a programmable store time. The retained value is committed when that time ends. While the block is busy, every request is dropped, which models a bus that is locked out. Steps saturate at both ends of the range.

Top module: `wiper_store_ctrl`

## Requirements
- R1: While reset is asserted, `wiper` is mid-scale (64 for the default width) and `busy` is 1. Reset does not change the retained register.
- R2: After reset is released, `busy` stays 1 for exactly RECALL_CYCLES rising edges. At the last of those edges `wiper` takes the retained value and `busy` falls.
- R3: A write (`req_op` = 2'b00) with `req_sel` = 0 loads `req_data[6:0]` into `wiper` at the accepting edge and leaves `busy` at 0. Bit 7 of `req_data` is ignored, and the retained register is unchanged.
- R4: A write with `req_sel` = 1 loads `req_data[6:0]` into `wiper` at the accepting edge and raises `busy` for exactly STORE_CYCLES edges. The retained register holds the new value once `busy` falls.
- R5: A read (`req_op` = 2'b01) sets `rd_valid` for one cycle after the accepting edge. `rd_data` is then {1'b0, position} when `req_sel` = 0, or {1'b0, retained} when `req_sel` = 1. A read never changes `wiper`.
- R6: A step (`req_op` = 2'b10) moves `wiper` up by one when `step_up` = 1 and down by one when `step_up` = 0. It holds at 127 going up and at 0 going down, and never wraps.
- R7: Any request that arrives while `busy` is 1 is dropped. This includes a request in the last busy cycle: `wiper` does not change and `rd_valid` stays 0.
- R8: The reserved code `req_op` = 2'b11 has no effect on `wiper`, `busy` or `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset that models a supply loss |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 2 | 00 write, 01 read, 10 step, 11 reserved |
| req_sel | input | 1 | Target register: 0 position, 1 retained |
| req_data | input | 8 | Write data; only the low 7 bits are used |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| wiper | output | 7 | Tap code that drives the resistor ladder |
| rd_data | output | 8 | Read data, MSB always 0 |
| rd_valid | output | 1 | Read data valid, one-cycle pulse |
| busy | output | 1 | High during the settle time and during a store |

## Verification
Two events can fall in the same cycle: the store timer expiring and a new request arriving on the last busy cycle. The bench counts edges from the accepted retained write and drives a position write so that it is sampled on the very edge where `busy` falls. The position code must keep the stored value, and a later read of the retained register must return the committed value. The settle-time expiry is checked in the same way, edge by edge: mid-scale must still be on `wiper` one edge before the end of the settle time, and the recalled value one edge after.

// File: rtl/wiper_store_ctrl.sv
module wiper_store_ctrl #(
  parameter int unsigned WIDTH         = 7,
  parameter int unsigned RECALL_CYCLES = 16,
  parameter int unsigned STORE_CYCLES  = 64,
  parameter logic [WIDTH-1:0] NV_INIT  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic             req_sel,
  input  logic [WIDTH:0]   req_data,
  input  logic             step_up,
  output logic [WIDTH-1:0] wiper,
  output logic [WIDTH:0]   rd_data,
  output logic             rd_valid,
  output logic             busy
);
  localparam int unsigned LONGEST = (RECALL_CYCLES > STORE_CYCLES) ? RECALL_CYCLES : STORE_CYCLES;
  localparam int unsigned CW      = $clog2(LONGEST) + 1;
  localparam logic [WIDTH-1:0] MID  = WIDTH'(1) << (WIDTH - 1);
  localparam logic [WIDTH-1:0] TOP  = '1;
  localparam logic [1:0] OP_WR = 2'b00, OP_RD = 2'b01, OP_STEP = 2'b10;

  typedef enum logic [1:0] {PH_RECALL, PH_IDLE, PH_STORE} phase_t;

  phase_t          phase;
  logic [CW-1:0]   cnt;
  logic [WIDTH-1:0] pos_q, nv_q, pend_q;

  wire [WIDTH-1:0] wr_val  = WIDTH'(req_data);
  wire             take    = req_valid && (phase == PH_IDLE);
  wire             expired = (cnt == '0);
  wire             commit  = (phase == PH_STORE) && expired;
  wire [WIDTH-1:0] stepped = step_up ? ((pos_q == TOP) ? pos_q : pos_q + 1'b1)
                                     : ((pos_q == '0)  ? pos_q : pos_q - 1'b1);

  initial nv_q = NV_INIT;

  always @(posedge clk)
    if (commit) nv_q <= pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_RECALL;
      cnt      <= CW'(RECALL_CYCLES - 1);
      pos_q    <= MID;
      pend_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (phase)
        PH_RECALL: begin
          if (expired) begin
            pos_q <= nv_q;
            phase <= PH_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        PH_STORE: begin
          if (expired) phase <= PH_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: begin
          if (take) begin
            case (req_op)
              OP_WR: begin
                pos_q <= wr_val;
                if (req_sel) begin
                  pend_q <= wr_val;
                  cnt    <= CW'(STORE_CYCLES - 1);
                  phase  <= PH_STORE;
                end
              end
              OP_RD: begin
                rd_valid <= 1'b1;
                rd_data  <= {1'b0, req_sel ? nv_q : pos_q};
              end
              OP_STEP: pos_q <= stepped;
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  assign wiper = pos_q;
  assign busy  = (phase != PH_IDLE);
endmodule

module wiper_store_ctrl_chk #(
  parameter int unsigned WIDTH = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_op,
  input logic             req_sel,
  input logic [WIDTH:0]   req_data,
  input logic             step_up,
  input logic [WIDTH-1:0] wiper,
  input logic [WIDTH:0]   rd_data,
  input logic             rd_valid,
  input logic             busy
);
  localparam logic [WIDTH-1:0] MID = WIDTH'(1) << (WIDTH - 1);
  localparam logic [WIDTH:0] LOWMASK = {1'b0, {WIDTH{1'b1}}};
  wire accept = req_valid && !busy;

  p_mid_on_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (wiper == MID) && busy);

  p_frozen_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(wiper));

  p_pos_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == 2'b00 && !req_sel) |=>
      ({1'b0, wiper} == ($past(req_data) & LOWMASK)) && !busy);

  p_store_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == 2'b00 && req_sel) |=>
      busy && ({1'b0, wiper} == ($past(req_data) & LOWMASK)));

  p_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == 2'b01) |=> rd_valid && !rd_data[WIDTH] && $stable(wiper));

  p_top_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == 2'b10 && step_up && wiper == '1) |=> wiper == '1);

  p_bottom_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == 2'b10 && !step_up && wiper == '0) |=> wiper == '0);

  p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == 2'b11) |=> $stable(wiper) && !rd_valid && !busy);
endmodule

bind wiper_store_ctrl wiper_store_ctrl_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/wiper_store_ctrl_tb_top.sv
module wiper_store_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RC = 12;
  localparam int SC = 20;
  localparam logic [6:0] NVI = 7'd23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic req_sel = 1'b0;
  logic [7:0] req_data = '0;
  logic step_up = 1'b0;
  logic [6:0] wiper;
  logic [7:0] rd_data;
  logic rd_valid, busy;

  int n_tests = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_store_ctrl #(.WIDTH(7), .RECALL_CYCLES(RC), .STORE_CYCLES(SC), .NV_INIT(NVI)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_sel(req_sel),
    .req_data(req_data), .step_up(step_up), .wiper(wiper), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic sel, input logic [7:0] d, input logic up);
    req_valid = 1'b1; req_op = op; req_sel = sel; req_data = d; step_up = up;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    issue(2'b01, sel, 8'h00, 1'b0);
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R7 unexpected read data actual=%0d expected=none", rd_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_fail++;
          $display("FAIL %s actual=%0d expected=%0d", t, rd_data, e);
        end
      end
    end
  end

  task automatic power_cycle(input logic [6:0] recalled);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 mid-scale in reset", {1'b0, wiper}, 8'd64);
    check("R1 busy in reset", {7'd0, busy}, 8'd1);
    rst_n = 1'b1;
    repeat (RC - 1) @(negedge clk);
    check("R2 still mid one edge early", {1'b0, wiper}, 8'd64);
    check("R2 busy one edge early", {7'd0, busy}, 8'd1);
    @(negedge clk);
    check("R2 recalled value", {1'b0, wiper}, {1'b0, recalled});
    check("R2 busy released", {7'd0, busy}, 8'd0);
  endtask

  initial begin
    @(negedge clk);
    power_cycle(NVI);

    rd(1'b1, 8'd23, "R5 read retained");
    rd(1'b0, 8'd23, "R5 read position");

    issue(2'b00, 1'b0, 8'hC5, 1'b0);
    check("R3 position write drops bit7", {1'b0, wiper}, 8'h45);
    check("R3 no busy on position write", {7'd0, busy}, 8'd0);
    rd(1'b1, 8'd23, "R3 retained untouched");
    rd(1'b0, 8'h45, "R5 read after write");
    check("R5 read leaves position", {1'b0, wiper}, 8'h45);

    issue(2'b10, 1'b0, 8'h00, 1'b1);
    check("R6 step up", {1'b0, wiper}, 8'd70);
    issue(2'b10, 1'b0, 8'h00, 1'b0);
    check("R6 step down", {1'b0, wiper}, 8'd69);
    issue(2'b00, 1'b0, 8'd126, 1'b0);
    issue(2'b10, 1'b0, 8'h00, 1'b1);
    check("R6 step to top", {1'b0, wiper}, 8'd127);
    issue(2'b10, 1'b0, 8'h00, 1'b1);
    check("R6 clamp at top", {1'b0, wiper}, 8'd127);
    issue(2'b00, 1'b0, 8'd1, 1'b0);
    issue(2'b10, 1'b0, 8'h00, 1'b0);
    check("R6 step to bottom", {1'b0, wiper}, 8'd0);
    issue(2'b10, 1'b0, 8'h00, 1'b0);
    check("R6 clamp at bottom", {1'b0, wiper}, 8'd0);

    issue(2'b11, 1'b1, 8'h33, 1'b1);
    check("R8 reserved keeps position", {1'b0, wiper}, 8'd0);
    check("R8 reserved no read", {7'd0, rd_valid}, 8'd0);
    check("R8 reserved no busy", {7'd0, busy}, 8'd0);

    issue(2'b00, 1'b1, 8'h9A, 1'b0);
    check("R4 store loads position", {1'b0, wiper}, 8'h1A);
    check("R4 store raises busy", {7'd0, busy}, 8'd1);
    issue(2'b01, 1'b0, 8'h00, 1'b0);
    check("R7 read dropped while busy", {7'd0, rd_valid}, 8'd0);
    issue(2'b10, 1'b0, 8'h00, 1'b1);
    check("R7 step dropped while busy", {1'b0, wiper}, 8'h1A);
    repeat (SC - 3) @(negedge clk);
    check("R4 busy on last store edge", {7'd0, busy}, 8'd1);
    issue(2'b00, 1'b0, 8'd5, 1'b0);
    check("R4 busy falls after store time", {7'd0, busy}, 8'd0);
    check("R7 write on last busy cycle dropped", {1'b0, wiper}, 8'h1A);
    rd(1'b1, 8'h1A, "R4 retained committed");

    issue(2'b00, 1'b0, 8'd90, 1'b0);
    power_cycle(7'h1A);
    rd(1'b1, 8'h1A, "R1 retained survives reset");

    @(negedge clk);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R5 missing read responses actual=%0d expected=0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule